// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block takes eight level-sensitive device interrupt lines (PIRQ A through H) and one system control interrupt (SCI) and produces the input levels for two downstream interrupt controllers. One is a 16-line legacy controller and the other is a 24-line advanced controller. Each PIRQ has its own route byte. The route byte names a legacy line number and carries a disable flag. Any number of enabled PIRQs may share one legacy line, and the line level is then the OR of those PIRQs. On the advanced side the wiring is fixed: PIRQ n feeds line 16 + n and never shares that line with another PIRQ.

A 3-bit select code places the SCI on one of five lines. Lines 9, 10 and 11 are reached on both controllers. Lines 20 and 21 are reached on the advanced controller only. The remaining codes leave the SCI unconnected. For each PIRQ the block also reports the line that its interrupt actually reaches, so that system software can build its routing tables.

All routing state sits behind a small register port, which has a write strobe, a 4-bit address and 8-bit data, with read data returned in the same cycle. Every output is registered.

Top module: `irq_line_router`

## Requirements
- R1: After reset, every route byte reads 0x80, which means disabled with line 0. The SCI select reads 0. All registered outputs are 0 until the first clock edge after reset.
- R2: The route bytes for PIRQ A–D sit at addresses 0–3 and those for PIRQ E–H sit at addresses 8–11. A route byte keeps bit 7 (disable) and bits 4:0 (line number); bits 6:5 are dropped and read back as 0. Address 12 holds the SCI select in bits 2:0 and reads back {5'b0, code}. Any other address reads 0, and writes to it change nothing.
- R3: A legacy line is high when at least one PIRQ is high, has its disable bit clear, and has a line number equal to that legacy line.
- R4: While a PIRQ's disable bit is set, that PIRQ drives no legacy line.
- R5: A PIRQ whose route is enabled but whose line number is 16 or above drives no legacy line.
- R6: Advanced line 16 + n follows PIRQ n for every n in 0–7, whatever the route byte holds.
- R7: The SCI select codes map as follows: 0 to line 9, 1 to line 10, 2 to line 11, 3 to line 20, 4 to line 21. Codes 5–7 leave the SCI unrouted.
- R8: A routed SCI is ORed into its advanced line. When that line number is below 16, it is also ORed into the legacy line of the same number.
- R9: The route report for PIRQ n gives route_legacy[n] and a 5-bit line number in route_line[5n+4:5n]:
  - When the route is enabled and the line number is below 16, the report is 1 and that number.
  - When the route is enabled and the line number is 16 or above, the report is 0 and 31.
  - When the route is disabled, the report is 0 and 16 + n.
- R10: Each output reflects the inputs and registers exactly one clock edge after they change. A register write therefore reaches the outputs at the second edge after the write strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pirq_in | input | 8 | PIRQ A–H levels, where bit n is PIRQ n |
| sci_in | input | 1 | SCI level |
| legacy_irq | output | 16 | Legacy controller line levels |
| adv_irq | output | 24 | Advanced controller line levels |
| route_legacy | output | 8 | Per-PIRQ flag: the route reaches a legacy line |
| route_line | output | 40 | Per-PIRQ reported line number, 5 bits each |

## Verification
The route table is loaded with three kinds of route at once:
- two PIRQs sharing legacy line 5;
- one route that is disabled;
- one route enabled at line 20, which has no legacy line.

Single-bit PIRQ patterns then separate the sharing case from the disable case and from the out-of-range case. Multi-bit patterns show whether the OR merge is complete. With all PIRQs high and every route disabled, the fixed advanced wiring is shown to ignore the route table. All eight SCI select codes are tried with the SCI high. In one case the SCI shares a legacy line with a PIRQ, so a missing OR term, a code that is wrongly routed, or a leak onto a legacy line from line 20 or 21 each give a mismatch.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int unsigned LINE_W = 5;
  localparam int unsigned SEL_W  = 3;

  typedef struct packed {
    logic              dis;
    logic [LINE_W-1:0] num;
  } route_t;

  localparam route_t ROUTE_RST = '{dis: 1'b1, num: '0};

  typedef enum logic [SEL_W-1:0] {
    SCI_TO_9  = 3'd0,
    SCI_TO_10 = 3'd1,
    SCI_TO_11 = 3'd2,
    SCI_TO_20 = 3'd3,
    SCI_TO_21 = 3'd4
  } sci_code_e;

  typedef struct packed {
    logic              hit;
    logic [LINE_W-1:0] line;
  } sci_tgt_t;

  function automatic sci_tgt_t sci_decode(input logic [SEL_W-1:0] code);
    sci_tgt_t t;
    t.hit = 1'b1;
    case (code)
      SCI_TO_9:  t.line = LINE_W'(9);
      SCI_TO_10: t.line = LINE_W'(10);
      SCI_TO_11: t.line = LINE_W'(11);
      SCI_TO_20: t.line = LINE_W'(20);
      SCI_TO_21: t.line = LINE_W'(21);
      default: begin
        t.hit  = 1'b0;
        t.line = '0;
      end
    endcase
    return t;
  endfunction

endpackage

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SCI_ADDR = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output route_t [NUM_PIRQ-1:0]     routes,
  output logic [SEL_W-1:0]          sci_sel
);

  localparam int unsigned GROUP = 4;

  function automatic logic [ADDR_W-1:0] slot_addr(input int unsigned i);
    return ADDR_W'((i / GROUP) * (2 * GROUP) + (i % GROUP));
  endfunction

  route_t [NUM_PIRQ-1:0] route_q, route_d;
  logic   [SEL_W-1:0]    sel_q, sel_d;

  // next state
  always_comb begin
    route_d = route_q;
    sel_d   = sel_q;
    for (int unsigned i = 0; i < NUM_PIRQ; i++) begin
      if (addr == slot_addr(i)) begin
        route_d[i].dis = wdata[DATA_W-1];
        route_d[i].num = wdata[LINE_W-1:0];
      end
    end
    if (addr == ADDR_W'(SCI_ADDR)) begin
      sel_d = wdata[SEL_W-1:0];
    end
  end

  // registers, enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= {NUM_PIRQ{ROUTE_RST}};
      sel_q   <= '0;
    end else if (wr_en) begin
      route_q <= route_d;
      sel_q   <= sel_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    for (int unsigned i = 0; i < NUM_PIRQ; i++) begin
      if (addr == slot_addr(i)) begin
        rdata[DATA_W-1]   = route_q[i].dis;
        rdata[LINE_W-1:0] = route_q[i].num;
      end
    end
    if (addr == ADDR_W'(SCI_ADDR)) begin
      rdata[SEL_W-1:0] = sel_q;
    end
  end

  assign routes  = route_q;
  assign sci_sel = sel_q;

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:2] == 2'b01) |=> ($stable(route_q) && $stable(sel_q))); // R2

endmodule

// File: rtl/irq_legacy_merge.sv
module irq_legacy_merge
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = 8,
  parameter int unsigned LEG_LINES = 16
) (
  input  route_t [NUM_PIRQ-1:0] routes,
  input  logic [NUM_PIRQ-1:0]   pirq,
  input  logic                  sci,
  input  sci_tgt_t              sci_tgt,
  output logic [LEG_LINES-1:0]  leg
);

  always_comb begin
    leg = '0;
    for (int unsigned l = 0; l < LEG_LINES; l++) begin
      for (int unsigned i = 0; i < NUM_PIRQ; i++) begin
        if (pirq[i] && !routes[i].dis && routes[i].num == LINE_W'(l)) begin
          leg[l] = 1'b1;
        end
      end
      if (sci && sci_tgt.hit && sci_tgt.line == LINE_W'(l)) begin
        leg[l] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_adv_merge.sv
module irq_adv_merge
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = 8,
  parameter int unsigned LEG_LINES = 16,
  parameter int unsigned ADV_LINES = 24
) (
  input  logic [NUM_PIRQ-1:0]  pirq,
  input  logic                 sci,
  input  sci_tgt_t             sci_tgt,
  output logic [ADV_LINES-1:0] adv
);

  for (genvar j = 0; j < ADV_LINES; j++) begin : g_line
    logic sci_here;
    assign sci_here = sci && sci_tgt.hit && (sci_tgt.line == LINE_W'(j));
    if (j >= LEG_LINES && j < LEG_LINES + NUM_PIRQ) begin : g_pirq
      assign adv[j] = pirq[j - LEG_LINES] | sci_here;
    end else begin : g_sci_only
      assign adv[j] = sci_here;
    end
  end

endmodule

// File: rtl/irq_route_report.sv
module irq_route_report
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = 8,
  parameter int unsigned LEG_LINES = 16
) (
  input  route_t [NUM_PIRQ-1:0]        routes,
  output logic [NUM_PIRQ-1:0]          rep_legacy,
  output logic [NUM_PIRQ*LINE_W-1:0]   rep_line
);

  localparam logic [LINE_W-1:0] NO_LINE = '1;

  for (genvar i = 0; i < NUM_PIRQ; i++) begin : g_rep
    always_comb begin
      if (routes[i].dis) begin
        rep_legacy[i]                 = 1'b0;
        rep_line[i*LINE_W +: LINE_W]  = LINE_W'(LEG_LINES + i);
      end else if (routes[i].num < LINE_W'(LEG_LINES)) begin
        rep_legacy[i]                 = 1'b1;
        rep_line[i*LINE_W +: LINE_W]  = routes[i].num;
      end else begin
        rep_legacy[i]                 = 1'b0;
        rep_line[i*LINE_W +: LINE_W]  = NO_LINE;
      end
    end
  end

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router
  import irq_router_pkg::*;
#(
  parameter int unsigned NUM_PIRQ  = 8,
  parameter int unsigned LEG_LINES = 16,
  parameter int unsigned ADV_LINES = 24,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_wr,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic [NUM_PIRQ-1:0]         pirq_in,
  input  logic                        sci_in,
  output logic [LEG_LINES-1:0]        legacy_irq,
  output logic [ADV_LINES-1:0]        adv_irq,
  output logic [NUM_PIRQ-1:0]         route_legacy,
  output logic [NUM_PIRQ*LINE_W-1:0]  route_line
);

  localparam int unsigned REP_W = NUM_PIRQ * LINE_W;

  route_t [NUM_PIRQ-1:0] routes;
  logic [SEL_W-1:0]      sci_sel;
  sci_tgt_t              sci_tgt;
  logic [LEG_LINES-1:0]  leg_d;
  logic [ADV_LINES-1:0]  adv_d;
  logic [NUM_PIRQ-1:0]   rep_leg_d;
  logic [REP_W-1:0]      rep_line_d;
  logic                  vld_q;

  irq_route_regs #(
    .NUM_PIRQ (NUM_PIRQ),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .routes  (routes),
    .sci_sel (sci_sel)
  );

  assign sci_tgt = sci_decode(sci_sel);

  irq_legacy_merge #(
    .NUM_PIRQ  (NUM_PIRQ),
    .LEG_LINES (LEG_LINES)
  ) u_leg (
    .routes  (routes),
    .pirq    (pirq_in),
    .sci     (sci_in),
    .sci_tgt (sci_tgt),
    .leg     (leg_d)
  );

  irq_adv_merge #(
    .NUM_PIRQ  (NUM_PIRQ),
    .LEG_LINES (LEG_LINES),
    .ADV_LINES (ADV_LINES)
  ) u_adv (
    .pirq    (pirq_in),
    .sci     (sci_in),
    .sci_tgt (sci_tgt),
    .adv     (adv_d)
  );

  irq_route_report #(
    .NUM_PIRQ  (NUM_PIRQ),
    .LEG_LINES (LEG_LINES)
  ) u_rep (
    .routes     (routes),
    .rep_legacy (rep_leg_d),
    .rep_line   (rep_line_d)
  );

  // output registers, always enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy_irq   <= '0;
      adv_irq      <= '0;
      route_legacy <= '0;
      route_line   <= '0;
      vld_q        <= 1'b0;
    end else begin
      legacy_irq   <= leg_d;
      adv_irq      <= adv_d;
      route_legacy <= rep_leg_d;
      route_line   <= rep_line_d;
      vld_q        <= 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> (legacy_irq == '0 && adv_irq == '0 && route_legacy == '0)); // R1

  AST_SCI_HIGH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && $past(sci_in) && $past(sci_sel) == SCI_TO_21)
      |-> (adv_irq[21] && !(|legacy_irq[LEG_LINES-1:0] & 1'b0))); // R8

  for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_chk
    AST_ADV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(pirq_in[n])) |-> adv_irq[LEG_LINES+n]); // R6

    AST_LEG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(pirq_in[n] && !routes[n].dis && routes[n].num < LINE_W'(LEG_LINES)))
        |-> |(legacy_irq & (LEG_LINES'(1) << $past(routes[n].num)))); // R3

    AST_DIS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q && $past(routes[n].dis))
        |-> (!route_legacy[n] && route_line[n*LINE_W +: LINE_W] == LINE_W'(LEG_LINES + n))); // R9
  end

endmodule

// File: tb/tb_irq_line_router.sv
`timescale 1ns/1ps
module tb_irq_line_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic [7:0]  pirq_in;
  logic        sci_in;
  logic [15:0] legacy_irq;
  logic [23:0] adv_irq;
  logic [7:0]  route_legacy;
  logic [39:0] route_line;

  always #2.5 clk = ~clk;

  irq_line_router dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .pirq_in      (pirq_in),
    .sci_in       (sci_in),
    .legacy_irq   (legacy_irq),
    .adv_irq      (adv_irq),
    .route_legacy (route_legacy),
    .route_line   (route_line)
  );

  typedef struct {
    logic [15:0] leg;
    logic [23:0] adv;
    logic [7:0]  mode;
    logic [39:0] line;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  rb[8];
  logic [2:0]  ssel;
  int          checks = 0;
  int          errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [7:0] p, input logic s, input string tag);
    exp_t e;
    int   t;
    e.leg = '0; e.adv = '0; e.mode = '0; e.line = '0; e.tag = tag;
    for (int i = 0; i < 8; i++) begin
      logic [4:0] num;
      num = rb[i][4:0];
      e.adv[16+i] = p[i];
      if (rb[i][7]) begin
        e.line[i*5 +: 5] = 5'(16 + i);
      end else if (num < 16) begin
        e.mode[i] = 1'b1;
        e.line[i*5 +: 5] = num;
        if (p[i]) e.leg[num] = 1'b1;
      end else begin
        e.line[i*5 +: 5] = 5'd31;
      end
    end
    case (ssel)
      3'd0: t = 9;
      3'd1: t = 10;
      3'd2: t = 11;
      3'd3: t = 20;
      3'd4: t = 21;
      default: t = -1;
    endcase
    if (s && t >= 0) begin
      e.adv[t] = 1'b1;
      if (t < 16) e.leg[t] = 1'b1;
    end
    return e;
  endfunction

  // driver: apply one input pattern, queue what the outputs must show one edge later
  task automatic step(input logic [7:0] p, input logic s, input string tag);
    @(negedge clk);
    pirq_in = p;
    sci_in  = s;
    @(posedge clk);
    #1 sb.push_back(model(p, s, tag));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    if (a < 4)                 rb[a]     = d & 8'h9F;
    else if (a >= 8 && a < 12) rb[a - 4] = d & 8'h9F;
    else if (a == 12)          ssel      = d[2:0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 64'(reg_rdata), 64'(exp));
  endtask

  // monitor: pop and compare at the negedge after the capturing edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " legacy"}, 64'(legacy_irq), 64'(e.leg));
      chk({e.tag, " adv"},    64'(adv_irq),    64'(e.adv));
      chk({e.tag, " mode"},   64'(route_legacy), 64'(e.mode));
      chk({e.tag, " line"},   64'(route_line), 64'(e.line));
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pirq_in = '0; sci_in = 1'b0;
    for (int i = 0; i < 8; i++) rb[i] = 8'h80;
    ssel = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 legacy after reset", 64'(legacy_irq), 64'd0);
    chk("R1 adv after reset", 64'(adv_irq), 64'd0);
    chk("R1 report after reset", 64'(route_legacy), 64'd0);

    for (int i = 0; i < 4; i++) rd(4'(i), 8'h80, "R1 route A-D");
    for (int i = 8; i < 12; i++) rd(4'(i), 8'h80, "R1 route E-H");
    rd(4'd12, 8'h00, "R1 sci select");
    step(8'h00, 1'b0, "R1 disabled report");

    // fixed advanced wiring while every route is disabled
    step(8'hFF, 1'b0, "R6 all high");
    step(8'h5A, 1'b0, "R6 mixed");

    // route table
    wr(4'd0,  8'h05);
    wr(4'd1,  8'h05);
    wr(4'd2,  8'h09);
    wr(4'd3,  8'h14);
    wr(4'd8,  8'h83);
    wr(4'd9,  8'h0F);
    wr(4'd10, 8'h00);
    wr(4'd11, 8'h6B);
    rd(4'd11, 8'h0B, "R2 bits 6:5 dropped");
    rd(4'd3,  8'h14, "R2 line 20 stored");
    rd(4'd8,  8'h83, "R2 disable bit kept");
    wr(4'd5,  8'h07);
    for (int i = 4; i < 8; i++) rd(4'(i), 8'h00, "R2 unmapped reads 0");
    rd(4'd0, 8'h05, "R2 route A unchanged");
    rd(4'd1, 8'h05, "R2 route B unchanged");

    step(8'h01, 1'b0, "R3 single A");
    step(8'h03, 1'b0, "R3 shared line 5");
    step(8'h02, 1'b0, "R3 single B");
    step(8'h08, 1'b0, "R5 line 20 no legacy");
    step(8'h10, 1'b0, "R4 disabled E");
    step(8'hFF, 1'b0, "R3 all high");
    step(8'hA5, 1'b0, "R3 pattern a5");
    step(8'h40, 1'b0, "R3 G to line 0");
    step(8'h00, 1'b0, "R10 back to zero");

    // disabling a route while its input is held
    wr(4'd0, 8'h87);
    step(8'h01, 1'b0, "R4 A disabled");
    step(8'h01, 1'b0, "R9 A report");

    // SCI select codes
    for (int c = 0; c < 8; c++) begin
      wr(4'd12, 8'(c));
      step(8'h00, 1'b1, "R7 sci code");
      step(8'h00, 1'b0, "R8 sci low");
    end
    wr(4'd12, 8'hFA);
    rd(4'd12, 8'h02, "R2 sci select field");
    step(8'h80, 1'b1, "R8 sci shares 11");
    step(8'h80, 1'b0, "R8 pirq only on 11");
    wr(4'd12, 8'h04);
    step(8'h20, 1'b1, "R8 sci on 21 with F");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule